// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator with Dead Band

This block drives three inverter phases. Each phase has a pair of complementary outputs. A pair of up/down triangle counters sets the carrier. The lower counter sweeps between zero and the half-period value. The upper counter runs the same sweep shifted up by the dead-band value, so it turns between the dead-band value and half-period plus dead band. For each phase, the high-side output compares its duty value against the upper counter and the low-side output compares it against the lower counter. Because the two counters sit a fixed distance apart, every switching edge gets a gap in which neither side conducts.

Software reaches the block through a word-wide register port with a single-cycle write strobe and a combinational read. Duty values and the half period are staged through buffers that are always writable. A write to the period buffer commits the whole set into hidden holding registers. The holding registers reach the live compare and period registers only when both counters reach their crest. A protect bit decides whether writes to the counters, the dead-band value, the live period and the live compares take effect. A read-only subcounter restarts at every counter turn and counts up to the dead-band value.

Register offsets: 0 control (bit 0 run), 1 protect (bit 0 write enable), 2 upper counter, 3 lower counter, 4 dead band, 5 live half period, 6 period buffer, 7 subcounter, 8 to 10 live compares for phases 0 to 2, 11 to 13 duty buffers for phases 0 to 2. Any other offset reads as zero.

Top module: `tri_pwm3`

## Requirements
- R1: After reset, every register at offsets 0 to 13 reads zero and all six outputs are low.
- R2: Writing 1 to control bit 0 (offset 0) while the block is stopped loads the upper counter with the dead-band value and the lower counter with zero. From the next clock on, both counters count up by one per clock.
- R3: While running, the lower counter rises to the half-period value, then falls back to zero, and repeats. The upper counter always reads the lower counter plus the dead band. A turn happens in the clock after a counter reaches its limit.
- R4: Writes to offsets 2, 3, 4, 5 and 8 to 10 take effect only while protect bit 0 (offset 1) is 1. Otherwise they leave the register unchanged.
- R5: The duty buffers (offsets 11 to 13) and the period buffer (offset 6) accept writes and read back whatever the protect bit is.
- R6: A write to the period buffer copies the three duty buffers and the written value into hidden holding registers. At the next crest, where the lower counter sits at the half period while rising, the holding values replace the live compares and the live period in a single clock. Buffer writes that are not followed by a period-buffer write never reach the live registers.
- R7: While running, the high-side output of phase i is 1 when its compare value is above the upper counter. The low-side output is 1 when the compare is below the lower counter and the high side is 0. The two outputs of a phase are never 1 together.
- R8: Clearing control bit 0 holds both counters at their current values and drives all outputs low. A later start reinitialises the counters as in R2.
- R9: The subcounter (offset 7) goes to zero on start and in the clock after each counter turn. Otherwise it rises by one per running clock and stops at the dead-band value. Writes to offset 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | AW (4) | Register offset |
| bus_wdata | input | W (16) | Write data |
| bus_rdata | output | W (16) | Read data for bus_addr, combinational |
| pwm_p | output | N (3) | High-side outputs, one per phase |
| pwm_n | output | N (3) | Low-side outputs, one per phase |

## Verification
The bench tracks the crest and the trough cycle by cycle against its own model of the triangle. A design that turned one clock early or late would show a counter off by one at every turn, and the subcounter would restart in the wrong cycle. The bench times the period-buffer commit so that the duty values change at the crest. A design that loaded the holding values at once, or that let a bare duty-buffer write through, would produce outputs that differ from the model within one half period. The bench also sets one compare value below the dead band and one above the upper counter's peak, and it stops and restarts mid-sweep. These cases catch overlapping complementary outputs, counters that keep moving after stop, and a restart that resumes instead of reloading.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

   // register offsets (fixed part of the map)
   localparam int unsigned OFS_CTRL     = 0;
   localparam int unsigned OFS_PROT     = 1;
   localparam int unsigned OFS_CNT_UP   = 2;
   localparam int unsigned OFS_CNT_LO   = 3;
   localparam int unsigned OFS_DEAD     = 4;
   localparam int unsigned OFS_PER      = 5;
   localparam int unsigned OFS_PER_BUF  = 6;
   localparam int unsigned OFS_SUB      = 7;
   localparam int unsigned OFS_CMP_BASE = 8;

   function automatic int unsigned buf_base(input int unsigned phases);
      return OFS_CMP_BASE + phases;
   endfunction

   function automatic int unsigned map_end(input int unsigned phases);
      return OFS_CMP_BASE + 2 * phases;
   endfunction

endpackage

// File: rtl/tpwm_tri_counter.sv
module tpwm_tri_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         init,
   input  logic [W-1:0] init_val,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   output logic [W-1:0] cnt,
   output logic         peak,
   output logic         floor_hit
);

   logic up_q;

   assign peak      = up_q && (cnt >= hi);
   assign floor_hit = !up_q && (cnt <= lo);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         up_q <= 1'b1;
      end else if (init) begin
         cnt  <= init_val;
         up_q <= 1'b1;
      end else if (ld) begin
         cnt <= ld_val;
      end else if (run) begin
         if (up_q) begin
            if (cnt >= hi) begin
               up_q <= 1'b0;
               if (cnt > lo) cnt <= cnt - 1'b1;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end else begin
            if (cnt <= lo) begin
               up_q <= 1'b1;
               if (cnt < hi) cnt <= cnt + 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/tpwm_deadsub.sv
module tpwm_deadsub #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         init,
   input  logic         turn,
   input  logic [W-1:0] dead,
   output logic [W-1:0] sub
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sub <= '0;
      end else if (init) begin
         sub <= '0;
      end else if (run) begin
         if (turn)            sub <= '0;
         else if (sub < dead) sub <= sub + 1'b1;
      end
   end

endmodule

// File: rtl/tpwm_phase.sv
module tpwm_phase #(
   parameter int W       = 16,
   parameter bit REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] cmp,
   input  logic [W-1:0] cnt_hi,
   input  logic [W-1:0] cnt_lo,
   output logic         pos,
   output logic         neg
);

   logic pos_c;
   logic neg_c;

   assign pos_c = run && (cmp > cnt_hi);
   assign neg_c = run && !pos_c && (cmp < cnt_lo);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pos <= 1'b0;
               neg <= 1'b0;
            end else begin
               pos <= pos_c;
               neg <= neg_c;
            end
         end
      end else begin : g_comb
         assign pos = pos_c;
         assign neg = neg_c;
      end
   endgenerate

endmodule

// File: rtl/tpwm_regs.sv
module tpwm_regs
   import tpwm_pkg::*;
#(
   parameter int W  = 16,
   parameter int N  = 3,
   parameter int AW = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic [AW-1:0]       addr,
   input  logic [W-1:0]        wdata,
   input  logic                crest,
   input  logic [W-1:0]        cnt_up,
   input  logic [W-1:0]        cnt_lo,
   input  logic [W-1:0]        sub,
   output logic [W-1:0]        rdata,
   output logic                run,
   output logic                start,
   output logic                ld_up,
   output logic                ld_lo,
   output logic                prot_en,
   output logic [W-1:0]        dead,
   output logic [W-1:0]        per,
   output logic [N-1:0][W-1:0] cmp
);

   localparam int unsigned CMP_LO = OFS_CMP_BASE;
   localparam int unsigned BUF_LO = buf_base(N);

   logic [W-1:0]        prot_q;
   logic                run_q;
   logic [W-1:0]        dead_q;
   logic [W-1:0]        per_q;
   logic [W-1:0]        per_buf_q;
   logic [W-1:0]        per_tmp_q;
   logic                pend_q;
   logic [N-1:0][W-1:0] duty_buf_q;
   logic [N-1:0][W-1:0] duty_tmp_q;
   logic                per_buf_wr;
   logic                commit;

   assign prot_en    = prot_q[0];
   assign run        = run_q;
   assign dead       = dead_q;
   assign per        = per_q;
   assign start      = wr && (addr == AW'(OFS_CTRL)) && wdata[0] && !run_q;
   assign ld_up      = wr && prot_en && (addr == AW'(OFS_CNT_UP));
   assign ld_lo      = wr && prot_en && (addr == AW'(OFS_CNT_LO));
   assign per_buf_wr = wr && (addr == AW'(OFS_PER_BUF));
   assign commit     = crest && pend_q;

   // fixed registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prot_q    <= '0;
         run_q     <= 1'b0;
         dead_q    <= '0;
         per_q     <= '0;
         per_buf_q <= '0;
         per_tmp_q <= '0;
         pend_q    <= 1'b0;
      end else begin
         if (wr && addr == AW'(OFS_PROT)) prot_q <= wdata;
         if (wr && addr == AW'(OFS_CTRL)) run_q <= wdata[0];
         if (wr && prot_en && addr == AW'(OFS_DEAD)) dead_q <= wdata;
         if (commit)
            per_q <= per_tmp_q;
         else if (wr && prot_en && addr == AW'(OFS_PER))
            per_q <= wdata;
         if (per_buf_wr) begin
            per_buf_q <= wdata;
            per_tmp_q <= wdata;
            pend_q    <= 1'b1;
         end else if (crest) begin
            pend_q <= 1'b0;
         end
      end
   end

   // per-phase buffer, holding and live compare registers
   generate
      for (genvar gi = 0; gi < N; gi++) begin : g_ch
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               duty_buf_q[gi] <= '0;
               duty_tmp_q[gi] <= '0;
               cmp[gi]        <= '0;
            end else begin
               if (wr && addr == AW'(BUF_LO + gi)) duty_buf_q[gi] <= wdata;
               if (per_buf_wr) duty_tmp_q[gi] <= duty_buf_q[gi];
               if (commit)
                  cmp[gi] <= duty_tmp_q[gi];
               else if (wr && prot_en && addr == AW'(CMP_LO + gi))
                  cmp[gi] <= wdata;
            end
         end
      end
   endgenerate

   // read path
   always_comb begin
      rdata = '0;
      case (addr)
         AW'(OFS_CTRL):    rdata = {{(W-1){1'b0}}, run_q};
         AW'(OFS_PROT):    rdata = prot_q;
         AW'(OFS_CNT_UP):  rdata = cnt_up;
         AW'(OFS_CNT_LO):  rdata = cnt_lo;
         AW'(OFS_DEAD):    rdata = dead_q;
         AW'(OFS_PER):     rdata = per_q;
         AW'(OFS_PER_BUF): rdata = per_buf_q;
         AW'(OFS_SUB):     rdata = sub;
         default:          rdata = '0;
      endcase
      for (int i = 0; i < N; i++) begin
         if (addr == AW'(CMP_LO + i)) rdata = cmp[i];
         if (addr == AW'(BUF_LO + i)) rdata = duty_buf_q[i];
      end
   end

endmodule

// File: rtl/tri_pwm3.sv
module tri_pwm3
   import tpwm_pkg::*;
#(
   parameter int W       = 16,
   parameter int N       = 3,
   parameter int AW      = 4,
   parameter bit REG_OUT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [W-1:0]  bus_wdata,
   output logic [W-1:0]  bus_rdata,
   output logic [N-1:0]  pwm_p,
   output logic [N-1:0]  pwm_n
);

   localparam int unsigned MAP_END = map_end(N);

   generate
      if (W < 2) begin : g_bad_w
         $error("tri_pwm3: W must be at least 2");
      end
      if (N < 1) begin : g_bad_n
         $error("tri_pwm3: N must be at least 1");
      end
      if (MAP_END > (1 << AW)) begin : g_bad_aw
         $error("tri_pwm3: AW too narrow for the register map");
      end
   endgenerate

   logic                run_w;
   logic                start_w;
   logic                ld_up_w;
   logic                ld_lo_w;
   logic                prot_en_w;
   logic [W-1:0]        dead_w;
   logic [W-1:0]        per_w;
   logic [N-1:0][W-1:0] cmp_w;
   logic [W-1:0]        cnt_up_w;
   logic [W-1:0]        cnt_lo_w;
   logic [W-1:0]        sub_w;
   logic [W-1:0]        hi_up;
   logic [W:0]          hi_sum;
   logic                up_peak;
   logic                up_floor;
   logic                lo_peak;
   logic                lo_floor;
   logic                crest_w;
   logic                turn_w;

   // upper limit of the shifted counter, clamped at full scale
   assign hi_sum  = {1'b0, per_w} + {1'b0, dead_w};
   assign hi_up   = hi_sum[W] ? '1 : hi_sum[W-1:0];
   assign crest_w = run_w && up_peak && lo_peak;
   assign turn_w  = crest_w || (run_w && up_floor && lo_floor);

   tpwm_regs #(.W(W), .N(N), .AW(AW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (bus_wr),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .crest   (crest_w),
      .cnt_up  (cnt_up_w),
      .cnt_lo  (cnt_lo_w),
      .sub     (sub_w),
      .rdata   (bus_rdata),
      .run     (run_w),
      .start   (start_w),
      .ld_up   (ld_up_w),
      .ld_lo   (ld_lo_w),
      .prot_en (prot_en_w),
      .dead    (dead_w),
      .per     (per_w),
      .cmp     (cmp_w)
   );

   tpwm_tri_counter #(.W(W)) u_cnt_up (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_w),
      .init      (start_w),
      .init_val  (dead_w),
      .ld        (ld_up_w),
      .ld_val    (bus_wdata),
      .lo        (dead_w),
      .hi        (hi_up),
      .cnt       (cnt_up_w),
      .peak      (up_peak),
      .floor_hit (up_floor)
   );

   tpwm_tri_counter #(.W(W)) u_cnt_lo (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run_w),
      .init      (start_w),
      .init_val  ('0),
      .ld        (ld_lo_w),
      .ld_val    (bus_wdata),
      .lo        ('0),
      .hi        (per_w),
      .cnt       (cnt_lo_w),
      .peak      (lo_peak),
      .floor_hit (lo_floor)
   );

   tpwm_deadsub #(.W(W)) u_sub (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run_w),
      .init  (start_w),
      .turn  (turn_w),
      .dead  (dead_w),
      .sub   (sub_w)
   );

   generate
      for (genvar gp = 0; gp < N; gp++) begin : g_ph
         tpwm_phase #(.W(W), .REG_OUT(REG_OUT)) u_ph (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run_w),
            .cmp    (cmp_w[gp]),
            .cnt_hi (cnt_up_w),
            .cnt_lo (cnt_lo_w),
            .pos    (pwm_p[gp]),
            .neg    (pwm_n[gp])
         );
      end
   endgenerate

endmodule

// File: rtl/tri_pwm3_chk.sv
module tri_pwm3_chk
   import tpwm_pkg::*;
#(
   parameter int W  = 16,
   parameter int N  = 3,
   parameter int AW = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [AW-1:0]       bus_addr,
   input logic [N-1:0]        pwm_p,
   input logic [N-1:0]        pwm_n,
   input logic                run,
   input logic                prot_en,
   input logic                crest,
   input logic [W-1:0]        dead,
   input logic [W-1:0]        cnt_up,
   input logic [W-1:0]        cnt_lo,
   input logic [W-1:0]        sub,
   input logic [N-1:0][W-1:0] cmp
);

   logic cmp_wr;
   assign cmp_wr = bus_wr && prot_en &&
                   (bus_addr >= AW'(OFS_CMP_BASE)) &&
                   (bus_addr < AW'(OFS_CMP_BASE + N));

   assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_p & pwm_n) == '0);

   assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && $past(!run)) |-> (pwm_p == '0 && pwm_n == '0));

   assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !bus_wr) |=> ($stable(cnt_up) && $stable(cnt_lo)));

   assert_start_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> (cnt_lo == '0 && cnt_up == dead));

   assert_dead_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !prot_en && bus_addr == AW'(OFS_DEAD)) |=> $stable(dead));

   assert_cmp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!crest && !cmp_wr) |=> $stable(cmp));

   assert_sub_readonly_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !run && bus_addr == AW'(OFS_SUB)) |=> $stable(sub));

endmodule

bind tri_pwm3 tri_pwm3_chk #(.W(W), .N(N), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .pwm_p    (pwm_p),
   .pwm_n    (pwm_n),
   .run      (run_w),
   .prot_en  (prot_en_w),
   .crest    (crest_w),
   .dead     (dead_w),
   .cnt_up   (cnt_up_w),
   .cnt_lo   (cnt_lo_w),
   .sub      (sub_w),
   .cmp      (cmp_w)
);

// File: tb/tri_pwm3_test.sv
`timescale 1ns/1ps
module tri_pwm3_test;

   localparam int W  = 16;
   localparam int N  = 3;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          bus_wr;
   logic [AW-1:0] bus_addr;
   logic [W-1:0]  bus_wdata;
   logic [W-1:0]  bus_rdata;
   logic [N-1:0]  pwm_p;
   logic [N-1:0]  pwm_n;

   int n_chk  = 0;
   int n_fail = 0;

   // reference model state
   int mb, md, mper, msub, mtper;
   bit mup, mpend;
   int mcmp[N];
   int mtmp[N];
   int mbuf[N];

   always #2.5 clk = ~clk;

   tri_pwm3 #(.W(W), .N(N), .AW(AW)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_p     (pwm_p),
      .pwm_n     (pwm_n)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // called at a falling edge: drive, let one rising edge pass, release
   task automatic wr_reg(input int a, input int d);
      bus_wr    = 1'b1;
      bus_addr  = AW'(a);
      bus_wdata = W'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input int a, output int v);
      bus_addr = AW'(a);
      #0.2;
      v = int'(bus_rdata);
   endtask

   task automatic model_start();
      mb = 0; mup = 1'b1; msub = 0;
   endtask

   task automatic model_step();
      bit crest, trough;
      int pold;
      crest  = mup && (mb >= mper);
      trough = !mup && (mb == 0);
      pold   = mper;
      if (crest && mpend) begin
         for (int i = 0; i < N; i++) mcmp[i] = mtmp[i];
         mper = mtper;
      end
      if (crest) mpend = 1'b0;
      if (crest || trough) msub = 0;
      else if (msub < md) msub = msub + 1;
      if (mup) begin
         if (mb >= pold) begin mup = 1'b0; if (mb > 0) mb = mb - 1; end
         else mb = mb + 1;
      end else begin
         if (mb == 0) begin mup = 1'b1; if (pold > 0) mb = mb + 1; end
         else mb = mb - 1;
      end
   endtask

   task automatic wr_run(input int a, input int d);
      wr_reg(a, d);
      model_step();
   endtask

   task automatic check_state();
      int va, vb, vs;
      bit ep, en;
      rd_reg(3, vb);
      check("R3", "lower counter", vb, mb);
      rd_reg(2, va);
      check("R3", "upper counter", va, mb + md);
      rd_reg(7, vs);
      check("R9", "subcounter", vs, msub);
      for (int i = 0; i < N; i++) begin
         ep = mcmp[i] > (mb + md);
         en = !ep && (mcmp[i] < mb);
         check("R7", $sformatf("high side %0d", i), int'(pwm_p[i]), int'(ep));
         check("R7", $sformatf("low side %0d", i), int'(pwm_n[i]), int'(en));
         check("R7", $sformatf("no overlap %0d", i), int'(pwm_p[i] & pwm_n[i]), 0);
      end
   endtask

   task automatic run_cycles(input int n);
      for (int k = 0; k < n; k++) begin
         check_state();
         @(negedge clk);
         model_step();
      end
   endtask

   task automatic t_reset();
      int v;
      for (int a = 0; a < 14; a++) begin
         rd_reg(a, v);
         check("R1", $sformatf("reset value @%0d", a), v, 0);
      end
      check("R1", "reset high sides", int'(pwm_p), 0);
      check("R1", "reset low sides", int'(pwm_n), 0);
   endtask

   task automatic t_protect();
      int v;
      wr_reg(4, 5);  rd_reg(4, v);  check("R4", "dead blocked", v, 0);
      wr_reg(3, 9);  rd_reg(3, v);  check("R4", "counter blocked", v, 0);
      wr_reg(8, 77); rd_reg(8, v);  check("R4", "compare blocked", v, 0);
      wr_reg(5, 40); rd_reg(5, v);  check("R4", "period blocked", v, 0);
      wr_reg(12, 55); rd_reg(12, v); check("R5", "duty buffer open", v, 55);
      wr_reg(1, 1);
      wr_reg(4, 3);  rd_reg(4, v);  check("R4", "dead enabled", v, 3);
      wr_reg(5, 10); rd_reg(5, v);  check("R4", "period enabled", v, 10);
      wr_reg(8, 2);  wr_reg(9, 8);  wr_reg(10, 14);
      rd_reg(9, v);  check("R4", "compare enabled", v, 8);
      wr_reg(3, 9);  rd_reg(3, v);  check("R4", "counter enabled", v, 9);
      rd_reg(12, v); check("R5", "duty buffer kept", v, 55);
      wr_reg(7, 9);  rd_reg(7, v);  check("R9", "subcounter write ignored", v, 0);
      md = 3; mper = 10; mcmp[0] = 2; mcmp[1] = 8; mcmp[2] = 14; mpend = 1'b0;
      mbuf[0] = 0; mbuf[1] = 55; mbuf[2] = 0;
   endtask

   task automatic t_run();
      int v;
      wr_reg(0, 1);
      model_start();
      rd_reg(2, v); check("R2", "upper starts at dead", v, 3);
      rd_reg(3, v); check("R2", "lower starts at zero", v, 0);
      run_cycles(45);
   endtask

   task automatic t_update();
      int v;
      wr_reg(1, 0);
      model_step();
      wr_run(11, 5);  mbuf[0] = 5;
      wr_run(12, 11); mbuf[1] = 11;
      wr_run(13, 1);  mbuf[2] = 1;
      rd_reg(13, v); check("R5", "duty buffer while protected", v, 1);
      run_cycles(25);
      rd_reg(8, v); check("R6", "no transfer without period write", v, 2);
      wr_run(6, 6);
      for (int i = 0; i < N; i++) mtmp[i] = mbuf[i];
      mtper = 6; mpend = 1'b1;
      rd_reg(6, v); check("R5", "period buffer readback", v, 6);
      rd_reg(8, v); check("R6", "live compare before crest", v, mcmp[0]);
      run_cycles(50);
      rd_reg(8, v); check("R6", "compare 0 after crest", v, 5);
      rd_reg(9, v); check("R6", "compare 1 after crest", v, 11);
      rd_reg(5, v); check("R6", "period after crest", v, 6);
      wr_run(11, 9);
      run_cycles(30);
      rd_reg(8, v); check("R6", "late buffer write held back", v, 5);
   endtask

   task automatic t_freeze();
      int b1, a1, v;
      wr_run(0, 0);
      rd_reg(3, b1);
      check("R8", "counter at stop", b1, mb);
      check("R8", "high sides low when stopped", int'(pwm_p), 0);
      check("R8", "low sides low when stopped", int'(pwm_n), 0);
      repeat (6) @(negedge clk);
      rd_reg(3, v); check("R8", "lower held", v, b1);
      rd_reg(2, a1); check("R8", "upper held", a1, b1 + md);
      rd_reg(7, v);
      wr_reg(1, 1);
      wr_reg(7, 1234);
      rd_reg(7, a1); check("R9", "subcounter write ignored stopped", a1, v);
      wr_reg(1, 0);
      wr_reg(2, 0);
      rd_reg(2, v); check("R4", "upper counter blocked", v, b1 + md);
      wr_reg(0, 1);
      model_start();
      rd_reg(3, v); check("R8", "restart reloads lower", v, 0);
      rd_reg(2, v); check("R8", "restart reloads upper", v, md);
      run_cycles(20);
   endtask

   initial begin
      #500000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      bus_wr    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_protect();
      t_run();
      t_update();
      t_freeze();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule